// File: doc/BRIEF.md
# Ethernet Receive Error Statistics Counters

This block sits beside an Ethernet receive path and keeps three 32-bit error tallies: frames with a bad CRC, frames with dribbling bits (alignment errors) and frames that were dropped. When a frame ends, the receive logic pulses an end-of-frame strobe and presents five status flags with it: address hit, CRC bad, dribble, no buffer and overrun. The block sorts the frame into at most one counter by fixed precedence. A dropped frame counts only as a discard. A dribbling frame counts only as an alignment error. A CRC error is counted only when the frame has no other fault and was meant for this station.

Software reads and writes the three counters through a small register port. The address picks a counter. A write replaces the value on the next clock edge, and a write takes precedence over a frame increment that lands on the same edge. Frame reception, CRC computation and buffer handling live elsewhere.

Top module: `rx_err_stats`

## Requirements
- R1: A synchronous reset sets all three counters to zero. Reads return zero after reset.
- R2: The CRC counter (register address 0) increments when the strobe comes with address hit and CRC bad set, and with dribble, no buffer and overrun all clear.
- R3: The alignment counter (address 1) increments when the strobe comes with address hit and dribble set, and with no buffer and overrun clear. This holds whatever the CRC flag is.
- R4: The discard counter (address 2) increments when the strobe comes with no buffer or overrun set. This holds whatever the CRC and address hit flags are.
- R5: A frame without address hit never changes the CRC or alignment counter.
- R6: Each frame raises at most one counter, and that counter rises by exactly one.
- R7: The status flags are ignored while the end-of-frame strobe is low.
- R8: A counter at 0xFFFF_FFFF that increments wraps to zero.
- R9: A write to an address stores its data on the next edge. If the same counter also has an increment on that edge, the written value wins.
- R10: Address 3 reads as zero, and writes to address 3 change no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_eof | input | 1 | End-of-frame strobe, one cycle per frame |
| rx_addr_hit | input | 1 | Frame was addressed to this station |
| rx_crc_bad | input | 1 | Frame CRC check failed |
| rx_dribble | input | 1 | Frame ended with dribbling bits |
| rx_no_buf | input | 1 | Frame arrived with no receive buffer free |
| rx_overrun | input | 1 | Receive overrun during the frame |
| reg_addr | input | 2 | Counter select: 0 CRC, 1 alignment, 2 discard |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected counter, combinational |

## Verification
Two functions can fall on the same edge: a software write to a counter, and a frame increment aimed at that same counter. The bench writes a chosen value to the alignment counter on the same edge as a dribbling, addressed frame. It then expects the written value exactly, with no +1 on top. It also pairs a write to one counter with a frame that raises a different counter, and expects both effects to appear.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;

  localparam int unsigned NUM_CNT = 3;

  typedef enum logic [1:0] {
    CNT_CRC   = 2'd0,
    CNT_ALIGN = 2'd1,
    CNT_DISC  = 2'd2
  } cnt_sel_e;

  typedef struct packed {
    logic addr_hit;
    logic crc_bad;
    logic dribble;
    logic no_buf;
    logic overrun;
  } rx_status_t;

  // Precedence: drop beats dribble, dribble beats CRC; the address gate applies to CRC and dribble only.
  function automatic logic [NUM_CNT-1:0] classify(input rx_status_t s, input logic eof);
    logic [NUM_CNT-1:0] v;
    logic dropped;
    v       = '0;
    dropped = s.no_buf | s.overrun;
    if (eof) begin
      if (dropped)
        v[CNT_DISC] = 1'b1;
      else if (s.addr_hit && s.dribble)
        v[CNT_ALIGN] = 1'b1;
      else if (s.addr_hit && s.crc_bad)
        v[CNT_CRC] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rx_err_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               eof,
  input  rx_status_t         status,
  output logic [NUM_CNT-1:0] inc_vec
);

  logic drop_evt;
  logic hit_evt;

  assign drop_evt = eof && (status.no_buf || status.overrun);
  assign hit_evt  = eof && status.addr_hit;
  assign inc_vec  = classify(status, eof);

  a_r6_one_counter: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc_vec));

  a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !eof |-> inc_vec == '0);

  a_r5_foreign_frame: assert property (@(posedge clk) disable iff (rst)
    (eof && !status.addr_hit) |-> (!inc_vec[CNT_CRC] && !inc_vec[CNT_ALIGN]));

  a_r4_drop_counts: assert property (@(posedge clk) disable iff (rst)
    drop_evt |-> inc_vec[CNT_DISC]);

  a_r3_drop_masks_align: assert property (@(posedge clk) disable iff (rst)
    (hit_evt && status.dribble && !drop_evt) |-> inc_vec[CNT_ALIGN]);

endmodule

// File: rtl/rx_err_counter.sv
module rx_err_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur, input logic bump,
                                              input logic load, input logic [W-1:0] val);
    if (load) return val;
    if (bump) return cur + ONE;
    return cur;
  endfunction

  logic load_evt;
  logic bump_evt;

  assign load_evt = wr;
  assign bump_evt = inc && !wr;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= next_count(q, inc, wr, wdata);
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> q == '0);

  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> q == $past(wdata));

  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (bump_evt && q == '1) |=> q == '0);

  a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
    bump_evt |=> q == $past(q) + ONE);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr) |=> $stable(q));

endmodule

// File: rtl/rx_err_regport.sv
module rx_err_regport
  import rx_err_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic [NUM_CNT*W-1:0] cnt_flat,
  output logic [NUM_CNT-1:0]   wr_vec,
  output logic [W-1:0]         rdata
);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    assign wr_vec[i] = wr && (addr == ADDR_W'(i));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr == ADDR_W'(i)) rdata = cnt_flat[i*W +: W];
    end
  end

  a_r10_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec));

  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (addr >= ADDR_W'(NUM_CNT)) |-> (rdata == '0 && wr_vec == '0));

endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
  import rx_err_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_eof,
  input  logic             rx_addr_hit,
  input  logic             rx_crc_bad,
  input  logic             rx_dribble,
  input  logic             rx_no_buf,
  input  logic             rx_overrun,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata
);

  localparam int unsigned ADDR_W = 2;

  rx_status_t               status;
  logic [NUM_CNT-1:0]       inc_vec;
  logic [NUM_CNT-1:0]       wr_vec;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;

  assign status = '{addr_hit: rx_addr_hit, crc_bad: rx_crc_bad, dribble: rx_dribble,
                    no_buf: rx_no_buf, overrun: rx_overrun};

  rx_frame_classifier u_cls (
    .clk     (clk),
    .rst     (rst),
    .eof     (rx_eof),
    .status  (status),
    .inc_vec (inc_vec)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    rx_err_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc_vec[i]),
      .wr    (wr_vec[i]),
      .wdata (reg_wdata),
      .q     (cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  rx_err_regport #(.W(CNT_W), .ADDR_W(ADDR_W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .cnt_flat (cnt_flat),
    .wr_vec   (wr_vec),
    .rdata    (reg_rdata)
  );

  a_r2_crc_only_clean: assert property (@(posedge clk) disable iff (rst)
    inc_vec[CNT_CRC] |-> (rx_addr_hit && rx_crc_bad && !rx_dribble && !rx_no_buf && !rx_overrun));

endmodule

// File: tb/sim_rx_err_stats.sv
module sim_rx_err_stats;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_eof, rx_addr_hit, rx_crc_bad, rx_dribble, rx_no_buf, rx_overrun;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] model [3];

  always #2 clk = ~clk;

  rx_err_stats u0 (
    .clk(clk), .rst(rst), .rx_eof(rx_eof), .rx_addr_hit(rx_addr_hit),
    .rx_crc_bad(rx_crc_bad), .rx_dribble(rx_dribble), .rx_no_buf(rx_no_buf),
    .rx_overrun(rx_overrun), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {eof, hit, crc, dribble, no_buf, overrun, exp_disc, exp_align, exp_crc}
  localparam logic [8:0] VEC [14] = '{
    9'b1_1_1_0_0_0_001,  // R2 clean CRC error
    9'b1_1_0_1_0_0_010,  // R3 dribble
    9'b1_1_1_1_0_0_010,  // R3 dribble masks CRC
    9'b1_1_0_0_1_0_100,  // R4 no buffer
    9'b1_1_1_0_0_1_100,  // R4 overrun with bad CRC
    9'b1_0_1_0_0_0_000,  // R5 foreign CRC
    9'b1_0_0_1_0_0_000,  // R5 foreign dribble
    9'b1_0_0_0_1_0_100,  // R4 foreign drop
    9'b0_1_1_0_0_0_000,  // R7 no strobe
    9'b0_0_0_0_1_0_000,  // R7 no strobe drop
    9'b1_1_0_0_0_0_000,  // R6 clean frame
    9'b1_1_1_1_1_1_100,  // R6 all faults
    9'b1_0_1_1_0_0_000,  // R5 foreign both
    9'b1_1_0_1_1_0_100   // R4 drop masks dribble
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 3; k++) read_chk(req, 2'(k), model[k]);
  endtask

  task automatic frame(input logic [5:0] f);
    {rx_eof, rx_addr_hit, rx_crc_bad, rx_dribble, rx_no_buf, rx_overrun} = f;
    @(posedge clk);
    @(negedge clk);
    {rx_eof, rx_addr_hit, rx_crc_bad, rx_dribble, rx_no_buf, rx_overrun} = '0;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    {rx_eof, rx_addr_hit, rx_crc_bad, rx_dribble, rx_no_buf, rx_overrun} = '0;
    for (int k = 0; k < 3; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    for (int i = 0; i < 14; i++) begin
      frame(VEC[i][8:3]);
      for (int k = 0; k < 3; k++) model[k] = model[k] + {31'd0, VEC[i][k]};
      check_all($sformatf("R2-vec%0d R6", i));
    end

    // R9 plain write
    write_reg(2'd0, 32'h1234_5678);
    model[0] = 32'h1234_5678;
    check_all("R9 write");

    // R9 write and increment to the same counter on one edge
    reg_addr = 2'd1; reg_wdata = 32'hCAFE_0001; reg_wr = 1'b1;
    frame(6'b110100);
    reg_wr = 1'b0;
    model[1] = 32'hCAFE_0001;
    check_all("R9 write wins");

    // R9 write one counter, frame raises another on the same edge
    reg_addr = 2'd0; reg_wdata = 32'h0000_00A0; reg_wr = 1'b1;
    frame(6'b100010);
    reg_wr = 1'b0;
    model[0] = 32'h0000_00A0; model[2] = model[2] + 32'd1;
    check_all("R9 independent");

    // R8 wrap on alignment counter
    write_reg(2'd1, 32'hFFFF_FFFF);
    frame(6'b110100);
    model[1] = 32'h0;
    check_all("R8 wrap");

    // R8 wrap on CRC counter
    write_reg(2'd0, 32'hFFFF_FFFF);
    frame(6'b111000);
    model[0] = 32'h0;
    check_all("R8 wrap crc");

    // R10 hole address
    write_reg(2'd3, 32'h5555_AAAA);
    read_chk("R10 hole read", 2'd3, 32'h0);
    check_all("R10 hole write");

    // R1 reset in mid run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) model[k] = '0;
    check_all("R1 reset again");

    finish_run();
  end

endmodule